// File: doc/BRIEF.md
# Operand address resolver

This block sits between instruction decode and execute in a small 24-bit processor. It takes one decoded memory-reference instruction, in either the short or the extended form. It forms the target address from the displacement or address field, the program counter, the base register and the index register. It then decides whether the instruction's operand is the target address itself, the word stored at the target address, or a word reached through one extra level of memory indirection. When the operand is indirect, the block makes one 24-bit read on its memory port and waits for the reply. It reports the outcome with a one-cycle `done` strobe that carries the operand, a flag that marks it as an immediate value, an illegal-mode flag, and a copy of the opcode.

Instructions enter through a valid/ready handshake. `in_ready` is high only while the block is idle. An instruction is taken on a clock edge where both `in_valid` and `in_ready` are high. While the block is busy, `in_valid` is ignored, so upstream must hold the instruction until it is taken. The result side has no back-pressure: `done` is a single-cycle strobe. The memory port is request/valid. `mem_req` and `mem_addr` stay constant until `mem_valid` is seen, and the memory may take any number of cycles to answer.

Top module: `opaddr_resolver`

## Requirements
- R1: A synchronous reset that is active-high (`rst`) returns the block to idle from any state, including a pending memory read. After reset, `in_ready`=1, `done`=0 and `mem_req`=0.
- R2: When opcode bits [1:0] are 00 (legacy mode), the target address is the 15-bit value {`in_flags`[2:0], `in_field`[11:0]}, zero-extended. `in_flags`[3] may add the index register to it. The result is an operand address, there is no memory read, and this mode is never illegal.
- R3: In the short form (`in_flags`[0]=0) with `in_flags`[2:1]=00, the target address is `in_field`[11:0] zero-extended. Bits [19:12] of the field are ignored.
- R4: With `in_flags`[1]=1 (PC-relative), the target address is `reg_pc` plus `in_field`[11:0] taken as a signed value from -2048 to 2047.
- R5: With `in_flags`[2]=1 (base-relative), the target address is `reg_base` plus `in_field`[11:0] taken as unsigned.
- R6: With `in_flags`[0]=1 (extended form), the target address is the full 20-bit `in_field`, zero-extended.
- R7: With `in_flags`[3]=1 (indexed) in simple or legacy mode, `reg_index` is added to the target address.
- R8: Opcode bits [1:0]=01 (immediate) give `res_data` = target address and `res_imm`=1, with no memory read.
- R9: Opcode bits [1:0]=10 (indirect) raise `mem_req` with `mem_addr` = target address bits [19:0], both held until `mem_valid`. `done` follows one cycle later with `res_data` = `mem_rdata` and `res_imm`=0. Opcode bits [1:0]=11 (simple) give `res_data` = target address, `res_imm`=0.
- R10: Outside legacy mode, each of these is illegal: indexing together with immediate or indirect, `in_flags`[2:1]=11, and the extended form with `in_flags`[2] or [1] set. An illegal instruction makes no memory read and gives `done` one cycle after acceptance, with `res_illegal`=1, `res_data`=0 and `res_imm`=0.
- R11: Each accepted instruction gives exactly one single-cycle `done`. This is one cycle after acceptance, or one cycle after `mem_valid`. `res_opcode` echoes the opcode. `in_ready` is low while busy, and `in_valid` is ignored then.
- R12: All target address arithmetic wraps modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle, instruction will be taken |
| in_opcode | input | 8 | Opcode byte; bit 1 = indirect flag, bit 0 = immediate flag |
| in_flags | input | 4 | [3] indexed, [2] base-relative, [1] PC-relative, [0] extended form |
| in_field | input | 20 | Displacement (bits 11:0) or extended address field |
| reg_pc | input | 24 | Program counter, already past the instruction |
| reg_base | input | 24 | Base register |
| reg_index | input | 24 | Index register |
| mem_req | output | 1 | Indirect word read pending |
| mem_addr | output | 20 | Word address of the indirect read |
| mem_valid | input | 1 | Read data present |
| mem_rdata | input | 24 | Read data word |
| done | output | 1 | One-cycle result strobe |
| res_data | output | 24 | Operand value (immediate) or operand address |
| res_imm | output | 1 | `res_data` is a value, not an address |
| res_illegal | output | 1 | Addressing combination rejected |
| res_opcode | output | 8 | Opcode of the finished instruction |

## Verification
A vector table covers each address-forming rule with displacements chosen to tell them apart. A displacement with bit 11 set separates signed PC-relative from unsigned base-relative. A field with high bits set separates the short form from the extended form. Legacy vectors set the base, PC-relative and extended bits, to show that they become address bits rather than mode selectors. Indirect vectors use memory words unlike their addresses, so an output of the address instead of the fetched word shows up. Each illegal combination is tried alone, and sums near 2^24 check wraparound. Directed tests hold `in_valid` high during a fetch, stretch the memory latency, and reset in the middle of a fetch.

// File: rtl/opres_pkg.sv
package opres_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RESP  = 2'd2
  } opres_state_e;

  // addressing interpretation taken from opcode bits [1:0]
  typedef enum logic [1:0] {
    AM_LEGACY = 2'b00,
    AM_IMM    = 2'b01,
    AM_IND    = 2'b10,
    AM_SIMPLE = 2'b11
  } amode_e;
endpackage

// File: rtl/opres_ta_calc.sv
module opres_ta_calc
  import opres_pkg::*;
#(
  parameter int WORD_W  = 24,
  parameter int FIELD_W = 20,
  parameter int DISP_W  = 12
) (
  input  amode_e              amode,
  input  logic                f_idx,
  input  logic                f_base,
  input  logic                f_pcrel,
  input  logic                f_ext,
  input  logic [FIELD_W-1:0]  field,
  input  logic [WORD_W-1:0]   pc,
  input  logic [WORD_W-1:0]   base,
  input  logic [WORD_W-1:0]   index,
  output logic [WORD_W-1:0]   ta,
  output logic                illegal
);
  localparam int LEG_W = DISP_W + 3;

  logic [WORD_W-1:0] disp_u, disp_s, ext_u, leg_u, pre_idx;
  logic [LEG_W-1:0]  leg_addr;

  assign leg_addr = {f_base, f_pcrel, f_ext, field[DISP_W-1:0]};
  assign disp_u   = WORD_W'(field[DISP_W-1:0]);
  assign disp_s   = {{(WORD_W-DISP_W){field[DISP_W-1]}}, field[DISP_W-1:0]};
  assign ext_u    = WORD_W'(field);
  assign leg_u    = WORD_W'(leg_addr);

  always_comb begin
    if (amode == AM_LEGACY)  pre_idx = leg_u;
    else if (f_ext)          pre_idx = ext_u;
    else if (f_pcrel)        pre_idx = pc + disp_s;
    else if (f_base)         pre_idx = base + disp_u;
    else                     pre_idx = disp_u;
    ta = pre_idx + (f_idx ? index : '0);
  end

  always_comb begin
    illegal = 1'b0;
    if (amode != AM_LEGACY) begin
      if (f_ext && (f_base || f_pcrel))                  illegal = 1'b1;
      if (f_base && f_pcrel)                             illegal = 1'b1;
      if (f_idx && (amode == AM_IMM || amode == AM_IND)) illegal = 1'b1;
    end
  end
endmodule

// File: rtl/opres_ctl.sv
module opres_ctl
  import opres_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 20,
  parameter int OPC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  amode_e            amode,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [WORD_W-1:0] ta,
  input  logic              illegal,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic [WORD_W-1:0] res_data,
  output logic              res_imm,
  output logic              res_illegal,
  output logic [OPC_W-1:0]  res_opcode
);
  opres_state_e      state_q;
  logic [WORD_W-1:0] data_q;
  logic              imm_q, ill_q;
  logic [OPC_W-1:0]  op_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      imm_q   <= 1'b0;
      ill_q   <= 1'b0;
      op_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (in_valid) begin
          op_q    <= opcode;
          ill_q   <= illegal;
          imm_q   <= !illegal && (amode == AM_IMM);
          data_q  <= illegal ? '0 : ta;
          state_q <= (!illegal && amode == AM_IND) ? ST_FETCH : ST_RESP;
        end
        ST_FETCH: if (mem_valid) begin
          data_q  <= mem_rdata;
          state_q <= ST_RESP;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready    = (state_q == ST_IDLE);
  assign mem_req     = (state_q == ST_FETCH);
  assign mem_addr    = data_q[ADDR_W-1:0];
  assign done        = (state_q == ST_RESP);
  assign res_data    = data_q;
  assign res_imm     = imm_q;
  assign res_illegal = ill_q;
  assign res_opcode  = op_q;
endmodule

// File: rtl/opaddr_resolver.sv
module opaddr_resolver
  import opres_pkg::*;
#(
  parameter int WORD_W  = 24,
  parameter int ADDR_W  = 20,
  parameter int FIELD_W = 20,
  parameter int DISP_W  = 12,
  parameter int OPC_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [OPC_W-1:0]   in_opcode,
  input  logic [3:0]         in_flags,
  input  logic [FIELD_W-1:0] in_field,
  input  logic [WORD_W-1:0]  reg_pc,
  input  logic [WORD_W-1:0]  reg_base,
  input  logic [WORD_W-1:0]  reg_index,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_valid,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic               done,
  output logic [WORD_W-1:0]  res_data,
  output logic               res_imm,
  output logic               res_illegal,
  output logic [OPC_W-1:0]   res_opcode
);
  amode_e            amode;
  logic [WORD_W-1:0] ta;
  logic              illegal;

  assign amode = amode_e'(in_opcode[1:0]);

  opres_ta_calc #(
    .WORD_W(WORD_W), .FIELD_W(FIELD_W), .DISP_W(DISP_W)
  ) u_ta (
    .amode  (amode),
    .f_idx  (in_flags[3]),
    .f_base (in_flags[2]),
    .f_pcrel(in_flags[1]),
    .f_ext  (in_flags[0]),
    .field  (in_field),
    .pc     (reg_pc),
    .base   (reg_base),
    .index  (reg_index),
    .ta     (ta),
    .illegal(illegal)
  );

  opres_ctl #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .OPC_W(OPC_W)
  ) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .amode      (amode),
    .opcode     (in_opcode),
    .ta         (ta),
    .illegal    (illegal),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_valid  (mem_valid),
    .mem_rdata  (mem_rdata),
    .done       (done),
    .res_data   (res_data),
    .res_imm    (res_imm),
    .res_illegal(res_illegal),
    .res_opcode (res_opcode)
  );
endmodule

// File: rtl/opaddr_resolver_chk.sv
module opaddr_resolver_chk #(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_valid,
  input logic              done,
  input logic [WORD_W-1:0] res_data,
  input logic              res_imm,
  input logic              res_illegal
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done) else $error("done wider than one cycle"); // R11
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst) (done || mem_req) |-> !in_ready) else $error("ready while busy"); // R11
  AST_ACCEPT_ADVANCES: assert property (@(posedge clk) disable iff (rst) (in_valid && in_ready) |=> (done || mem_req)) else $error("accept did not advance"); // R11
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst) (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr))) else $error("request dropped or moved"); // R9
  AST_FETCH_TO_DONE: assert property (@(posedge clk) disable iff (rst) (mem_req && mem_valid) |=> (done && !res_illegal && !res_imm)) else $error("fetch reply not reported"); // R9
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst) (done && res_illegal) |-> (res_data == '0 && !res_imm)) else $error("illegal result carries data"); // R10
endmodule

bind opaddr_resolver opaddr_resolver_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
  .done(done), .res_data(res_data), .res_imm(res_imm), .res_illegal(res_illegal)
);

// File: tb/opaddr_resolver_bench.sv
`timescale 1ns/1ps
module opaddr_resolver_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_opcode = '0;
  logic [3:0]  in_flags = '0;
  logic [19:0] in_field = '0;
  logic [23:0] reg_pc = '0, reg_base = '0, reg_index = '0;
  logic        mem_req;
  logic [19:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [23:0] mem_rdata = '0;
  logic        done;
  logic [23:0] res_data;
  logic        res_imm, res_illegal;
  logic [7:0]  res_opcode;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  opaddr_resolver u_opaddr_resolver (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_flags(in_flags), .in_field(in_field),
    .reg_pc(reg_pc), .reg_base(reg_base), .reg_index(reg_index),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .done(done), .res_data(res_data), .res_imm(res_imm), .res_illegal(res_illegal),
    .res_opcode(res_opcode)
  );

  typedef struct packed {
    logic [3:0]  tag;
    logic [7:0]  op;
    logic [3:0]  fl;
    logic [19:0] fld;
    logic [23:0] pc, bs, ix, mw, exp;
    logic        imm, ill, fetch;
    logic [19:0] maddr;
  } vec_t;

  localparam logic [23:0] P = 24'h003000, B = 24'h006000, X = 24'h000090;
  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{4'd3,  8'h03, 4'b0000, 20'h00ABC, P, B, X, 24'h0, 24'h000ABC, 1'b0, 1'b0, 1'b0, 20'h0},     // R3
    '{4'd3,  8'h03, 4'b0000, 20'hAB123, P, B, X, 24'h0, 24'h000123, 1'b0, 1'b0, 1'b0, 20'h0},     // R3 high bits ignored
    '{4'd4,  8'h1B, 4'b0010, 20'h0012D, P, B, X, 24'h0, 24'h00312D, 1'b0, 1'b0, 1'b0, 20'h0},     // R4
    '{4'd4,  8'h03, 4'b0010, 20'h00FF0, P, B, X, 24'h0, 24'h002FF0, 1'b0, 1'b0, 1'b0, 20'h0},     // R4 negative
    '{4'd5,  8'h6B, 4'b0100, 20'h00FF0, P, B, X, 24'h0, 24'h006FF0, 1'b0, 1'b0, 1'b0, 20'h0},     // R5 unsigned
    '{4'd6,  8'h03, 4'b0001, 20'hC1234, P, B, X, 24'h0, 24'h0C1234, 1'b0, 1'b0, 1'b0, 20'h0},     // R6
    '{4'd7,  8'h03, 4'b1000, 20'h00100, P, B, X, 24'h0, 24'h000190, 1'b0, 1'b0, 1'b0, 20'h0},     // R7
    '{4'd7,  8'h03, 4'b1010, 20'h00010, P, B, X, 24'h0, 24'h0030A0, 1'b0, 1'b0, 1'b0, 20'h0},     // R7 with PC-relative
    '{4'd8,  8'h01, 4'b0000, 20'h00005, P, B, X, 24'h0, 24'h000005, 1'b1, 1'b0, 1'b0, 20'h0},     // R8
    '{4'd8,  8'h01, 4'b0001, 20'hFFFFF, P, B, X, 24'h0, 24'h0FFFFF, 1'b1, 1'b0, 1'b0, 20'h0},     // R8 extended
    '{4'd8,  8'h01, 4'b0010, 20'h00800, P, B, X, 24'h0, 24'h002800, 1'b1, 1'b0, 1'b0, 20'h0},     // R8 PC-relative -2048
    '{4'd2,  8'h00, 4'b0111, 20'h00123, P, B, X, 24'h0, 24'h007123, 1'b0, 1'b0, 1'b0, 20'h0},     // R2
    '{4'd2,  8'h18, 4'b1101, 20'h00FFF, P, B, X, 24'h0, 24'h00608F, 1'b0, 1'b0, 1'b0, 20'h0},     // R2 indexed
    '{4'd9,  8'h02, 4'b0000, 20'h00200, P, B, X, 24'h0ABCDE, 24'h0ABCDE, 1'b0, 1'b0, 1'b1, 20'h00200}, // R9
    '{4'd9,  8'h02, 4'b0010, 20'h00020, P, B, X, 24'h000777, 24'h000777, 1'b0, 1'b0, 1'b1, 20'h03020}, // R9 PC-relative
    '{4'd10, 8'h01, 4'b1000, 20'h00005, P, B, X, 24'h0, 24'h0, 1'b0, 1'b1, 1'b0, 20'h0},          // R10 imm+index
    '{4'd10, 8'h02, 4'b1000, 20'h00200, P, B, X, 24'h0, 24'h0, 1'b0, 1'b1, 1'b0, 20'h0},          // R10 ind+index
    '{4'd10, 8'h03, 4'b0110, 20'h00010, P, B, X, 24'h0, 24'h0, 1'b0, 1'b1, 1'b0, 20'h0},          // R10 base+pc
    '{4'd10, 8'h03, 4'b0011, 20'h00010, P, B, X, 24'h0, 24'h0, 1'b0, 1'b1, 1'b0, 20'h0},          // R10 ext+pc
    '{4'd12, 8'h03, 4'b0100, 20'h00020, P, 24'hFFFFF0, X, 24'h0, 24'h000010, 1'b0, 1'b0, 1'b0, 20'h0},   // R12
    '{4'd12, 8'h03, 4'b0010, 20'h00FF0, 24'h000005, B, X, 24'h0, 24'hFFFFF5, 1'b0, 1'b0, 1'b0, 20'h0}    // R12 negative
  };

  task automatic chk(input bit ok, input int tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic offer(input vec_t v);
    in_valid  = 1'b1;
    in_opcode = v.op;
    in_flags  = v.fl;
    in_field  = v.fld;
    reg_pc    = v.pc;
    reg_base  = v.bs;
    reg_index = v.ix;
  endtask

  task automatic run_vec(input vec_t v, input int wait_n);
    int t;
    t = int'(v.tag);
    @(negedge clk);
    offer(v);
    @(negedge clk);
    in_valid = 1'b0;
    if (v.fetch) begin
      chk(mem_req == 1'b1, t, "mem_req", 32'(mem_req), 32'd1);
      chk(mem_addr == v.maddr, t, "mem_addr", 32'(mem_addr), 32'(v.maddr));
      for (int w = 0; w < wait_n; w++) begin
        @(negedge clk);
        chk(mem_req && !done, t, "held request", 32'(done), 32'd0);
        chk(mem_addr == v.maddr, t, "held mem_addr", 32'(mem_addr), 32'(v.maddr));
      end
      mem_valid = 1'b1;
      mem_rdata = v.mw;
      @(negedge clk);
      mem_valid = 1'b0;
      mem_rdata = '0;
    end
    chk(mem_req == 1'b0, t, "no memory read", 32'(mem_req), 32'd0);
    chk(done == 1'b1, t, "done", 32'(done), 32'd1);
    chk(res_data == v.exp, t, "res_data", 32'(res_data), 32'(v.exp));
    chk(res_imm == v.imm, t, "res_imm", 32'(res_imm), 32'(v.imm));
    chk(res_illegal == v.ill, t, "res_illegal", 32'(res_illegal), 32'(v.ill));
    chk(res_opcode == v.op, 11, "res_opcode", 32'(res_opcode), 32'(v.op)); // R11
    @(negedge clk);
    chk(done == 1'b0 && in_ready == 1'b1, 11, "single done", 32'(done), 32'd0); // R11
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, 1, "in_ready after reset", 32'(in_ready), 32'd1);
    chk(done == 1'b0, 1, "done after reset", 32'(done), 32'd0);
    chk(mem_req == 1'b0, 1, "mem_req after reset", 32'(mem_req), 32'd0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) run_vec(VEC[k], k % 4);

    // R11: in_valid ignored while a fetch is pending
    @(negedge clk);
    offer(VEC[13]);
    @(negedge clk);
    offer(VEC[8]);
    chk(in_ready == 1'b0, 11, "busy in_ready", 32'(in_ready), 32'd0);
    repeat (2) @(negedge clk);
    chk(mem_addr == 20'h00200, 11, "addr kept while busy", 32'(mem_addr), 32'h200);
    in_valid = 1'b0;
    mem_valid = 1'b1;
    mem_rdata = 24'h123456;
    @(negedge clk);
    mem_valid = 1'b0;
    chk(done && res_data == 24'h123456, 11, "first instr result", 32'(res_data), 32'h123456);
    chk(res_opcode == 8'h02, 11, "first instr opcode", 32'(res_opcode), 32'h02);
    @(negedge clk);
    chk(!done && !mem_req && in_ready, 11, "busy offer dropped", 32'(done), 32'd0);
    @(negedge clk);
    chk(!done, 11, "no second done", 32'(done), 32'd0);

    // R1: reset in the middle of a fetch
    offer(VEC[14]);
    @(negedge clk);
    in_valid = 1'b0;
    chk(mem_req == 1'b1, 1, "fetch started", 32'(mem_req), 32'd1);
    rst = 1'b1;
    @(negedge clk);
    chk(!mem_req && !done && in_ready, 1, "reset aborts fetch", 32'(mem_req), 32'd0);
    rst = 1'b0;
    run_vec(VEC[2], 0);
    run_vec(VEC[14], 5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule